// File: doc/BRIEF.md
# Privileged-Mode Entry and Return Controller

This block decides where the processor goes when it enters or leaves its privileged handler mode. Each cycle it looks at an event request (a cause code), a return request, the PC of the instruction that raised them, and the handler base address. From these it computes the new PC, the following PC and the address execution resumes at after the handler.

It also keeps the flag for the privileged mode and the select for a shadow bank of general registers. Only a fixed subset of register indices is redirected to the shadow bank. The instruction fetch logic reads `pc_q` whenever `redir_q` pulses. The register file asks, index by index, whether an access goes to the shadow copy.

Privilege of the instruction being executed is carried in bit 0 of its PC. A handler address has bit 0 set, and a normal-mode address has it clear. All state is updated on the rising clock edge. Reset is synchronous and active low.

Top module: `priv_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, `pc_q` equals `pal_base` (reset vector offset 0) and `npc_q` equals `pal_base`+4. `pal_q` and `bank_q` are 1, `restart_q` is 0, and `redir_q`, `swap_err_q` and `unsup_q` are 0.
- R2: `use_shadow` is 1 exactly when `bank_q` is 1 and `rf_idx` is one of 8, 9, 10, 11, 12, 13, 14 or 25. No other index is ever redirected.
- R3: An accepted event (`evt_valid`, code 0 memory fault, 1 opcode fault, 2 interrupt, 3 handler call) sets `pc_q` to `pal_base` + (code+1)*`VEC_STRIDE` and `npc_q` to `pc_q`+4. It also sets `pal_q` to 1 and pulses `redir_q` for one cycle.
- R4: For a fault or an interrupt, the saved `restart_q` is `cur_pc`. For a handler call it is `cur_pc`+4.
- R5: An interrupt taken while `cur_pc[0]` is 1 leaves `restart_q` unchanged.
- R6: An accepted entry with `cur_pc[0]` = 0 makes the shadow bank active. An entry with `cur_pc[0]` = 1 does not touch `bank_q`.
- R7: If the shadow bank is already active when an entry asks to switch it in, or already inactive when a return asks to switch it out, `swap_err_q` pulses for one cycle and `bank_q` keeps its value.
- R8: A return request with `cur_pc[0]` = 1 and no event sets `pc_q` to `restart_q`, `npc_q` to `restart_q`+4, and `pal_q` to bit 0 of `restart_q`. It also pulses `redir_q`.
- R9: A return deactivates the shadow bank only when bit 0 of `restart_q` is 0. If that bit is 1, `bank_q` stays 1.
- R10: A return request with `cur_pc[0]` = 0 is illegal. It is taken as an opcode fault (code 1): the vector of code 1, `restart_q` = `cur_pc`, and the shadow bank is switched in.
- R11: Event codes 4 (arithmetic trap) through 7 are unsupported. They pulse `unsup_q` and change no other output.
- R12: When `evt_valid` and `ret_req` are both high, the event is acted on and the return is ignored.
- R13: `pc_q`, `npc_q`, `pal_q` and `bank_q` all change on the same edge. In a cycle with no request, they hold and `redir_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | Event request this cycle |
| evt_cause | input | 3 | Event cause code |
| ret_req | input | 1 | Handler return request this cycle |
| cur_pc | input | AW | PC of the requesting instruction; bit 0 marks privileged mode |
| pal_base | input | AW | Handler base address |
| rf_idx | input | 5 | Register index being accessed |
| pc_q | output | AW | New program counter |
| npc_q | output | AW | Program counter after `pc_q` |
| restart_q | output | AW | Saved restart address |
| pal_q | output | 1 | Privileged-mode flag |
| bank_q | output | 1 | Shadow bank active |
| use_shadow | output | 1 | `rf_idx` is served by the shadow bank |
| redir_q | output | 1 | One-cycle pulse: fetch from `pc_q` |
| swap_err_q | output | 1 | One-cycle pulse: redundant bank swap request |
| unsup_q | output | 1 | One-cycle pulse: unsupported cause code |

## Verification
The bench goes after the cases where a design could keep the wrong restart address:
- An interrupt taken inside the handler must not overwrite the saved address. A design that always saves would lose the outer restart address.
- A handler call must save the address after the call. A design that treats a call like a fault would re-execute the call forever.

It also checks returns whose saved bit 0 is 1. These must stay privileged and keep the bank. A design that always swaps out on return would corrupt the handler's registers.

Redundant swaps are forced in both directions. This catches a design that toggles the bank blindly.

An illegal return from normal mode, an unsupported cause, and an event colliding with a return are also covered. For these, a wrong priority or a missing check shows up as a bad `pc_q` or a stray `redir_q`.

// File: rtl/pm_pkg.sv
// Package: shared cause codes and the shadow-register subset for the
// privileged-mode controller. Assumes a 32-entry integer register file.
package pm_pkg;
    typedef enum logic [2:0] {
        CZ_MEMF  = 3'd0,
        CZ_OPCF  = 3'd1,
        CZ_INTR  = 3'd2,
        CZ_CALL  = 3'd3,
        CZ_ARITH = 3'd4
    } cause_e;

    localparam int RF_REGS   = 32;
    localparam int RF_IDX_W  = $clog2(RF_REGS);
    localparam int NUM_VEC   = 4;

    // True for the register indices that have a shadow copy.
    function automatic logic is_shadowed(input int unsigned idx);
        return ((idx >= 8) && (idx <= 14)) || (idx == 25);
    endfunction
endpackage

// File: rtl/pm_vector.sv
// Module: pm_vector
// Maps a cause code to its handler vector offset. Supported codes 0..3 get
// offset (code+1)*STRIDE; code bit 2 set means unsupported (offset 0).
// Assumes STRIDE*(NUM_VEC) fits in AW bits.
module pm_vector #(
    parameter int AW     = 32,
    parameter int STRIDE = 'h80
) (
    input  logic [2:0]    cause,
    output logic [AW-1:0] offset,
    output logic          supported
);
    localparam int NV = pm_pkg::NUM_VEC;

    logic [AW-1:0] tbl [NV];

    // Build the offset table, one entry per supported cause.
    for (genvar g = 0; g < NV; g++) begin : g_vec
        assign tbl[g] = AW'((g + 1) * STRIDE);
    end

    // Select the entry for the requested cause.
    always_comb begin
        supported = ~cause[2];
        offset    = supported ? tbl[cause[1:0]] : '0;
    end
endmodule

// File: rtl/pm_restart.sv
// Module: pm_restart
// Holds the restart address saved on handler entry. Loads only when save_en.
module pm_restart #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_en,
    input  logic [AW-1:0] save_val,
    output logic [AW-1:0] restart_q
);
    // Capture the restart address on an entry that is allowed to save.
    always_ff @(posedge clk) begin
        if (!rst_n)       restart_q <= '0;
        else if (save_en) restart_q <= save_val;
    end

    // R4
    restart_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !save_en |=> $stable(restart_q));
endmodule

// File: rtl/pm_bank.sv
// Module: pm_bank
// Shadow bank select. Switches in/out on request, flags a request that asks
// for the state already held, and tells the register file per index whether
// the shadow copy is in use. Assumes swap_in and swap_out are never both set.
module pm_bank #(
    parameter int NREG = pm_pkg::RF_REGS,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          swap_in,
    input  logic          swap_out,
    input  logic [IW-1:0] rf_idx,
    output logic          bank_q,
    output logic          swap_err_q,
    output logic          use_shadow
);
    logic [NREG-1:0] redir_mask;
    logic            bad_req;

    // Fixed mask of redirected register indices.
    for (genvar i = 0; i < NREG; i++) begin : g_mask
        assign redir_mask[i] = pm_pkg::is_shadowed(i);
    end

    // A swap that asks for the current state is an error.
    assign bad_req = (swap_in && bank_q) || (swap_out && !bank_q);

    // Bank state and error pulse; the bank starts active out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q     <= 1'b1;
            swap_err_q <= 1'b0;
        end else begin
            swap_err_q <= bad_req;
            if (swap_in && !bank_q)       bank_q <= 1'b1;
            else if (swap_out && bank_q)  bank_q <= 1'b0;
        end
    end

    // Per-access redirect decision.
    assign use_shadow = bank_q && redir_mask[rf_idx];

    // R7
    err_keeps_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_err_q |-> $stable(bank_q));
    // R2
    shadow_needs_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        use_shadow |-> bank_q);
    // R6
    swap_in_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_in |=> bank_q);
endmodule

// File: rtl/priv_mode_ctrl.sv
// Module: priv_mode_ctrl
// Top of the privileged-mode entry/return controller. Decodes events and
// returns, computes new PC / next PC / restart address, drives the mode flag
// and the shadow bank. Assumes bit 0 of cur_pc marks privileged execution and
// that pal_base is stable while in use.
module priv_mode_ctrl #(
    parameter int AW     = 32,
    parameter int STRIDE = 'h80,
    localparam int IW    = pm_pkg::RF_IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_valid,
    input  logic [2:0]    evt_cause,
    input  logic          ret_req,
    input  logic [AW-1:0] cur_pc,
    input  logic [AW-1:0] pal_base,
    input  logic [IW-1:0] rf_idx,
    output logic [AW-1:0] pc_q,
    output logic [AW-1:0] npc_q,
    output logic [AW-1:0] restart_q,
    output logic          pal_q,
    output logic          bank_q,
    output logic          use_shadow,
    output logic          redir_q,
    output logic          swap_err_q,
    output logic          unsup_q
);
    import pm_pkg::*;

    localparam logic [AW-1:0] STEP = AW'(4);

    logic          in_pal, ret_ok, ret_bad, enter, unsup, sup;
    logic [2:0]    ent_cause;
    logic [AW-1:0] vec_off, entry_pc, save_val;
    logic          save_en, swap_in, swap_out;

    // Decode the request of this cycle; an event outranks a return.
    always_comb begin
        in_pal    = cur_pc[0];
        ret_ok    = !evt_valid && ret_req && in_pal;
        ret_bad   = !evt_valid && ret_req && !in_pal;
        ent_cause = ret_bad ? CZ_OPCF : evt_cause;
    end

    pm_vector #(.AW(AW), .STRIDE(STRIDE)) u_vec (
        .cause     (ent_cause),
        .offset    (vec_off),
        .supported (sup)
    );

    // Entry, save and swap decisions.
    always_comb begin
        enter    = (evt_valid && sup) || ret_bad;
        unsup    = evt_valid && !sup;
        entry_pc = pal_base + vec_off;
        save_en  = enter && !((ent_cause == CZ_INTR) && in_pal);
        save_val = (ent_cause == CZ_CALL) ? cur_pc + STEP : cur_pc;
        swap_in  = enter && !in_pal;
        swap_out = ret_ok && !restart_q[0];
    end

    pm_restart #(.AW(AW)) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .save_en   (save_en),
        .save_val  (save_val),
        .restart_q (restart_q)
    );

    pm_bank #(.NREG(RF_REGS)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .swap_in    (swap_in),
        .swap_out   (swap_out),
        .rf_idx     (rf_idx),
        .bank_q     (bank_q),
        .swap_err_q (swap_err_q),
        .use_shadow (use_shadow)
    );

    // PC, next PC, mode flag and pulses, all on one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= pal_base;
            npc_q   <= pal_base + STEP;
            pal_q   <= 1'b1;
            redir_q <= 1'b0;
            unsup_q <= 1'b0;
        end else begin
            redir_q <= enter || ret_ok;
            unsup_q <= unsup;
            if (enter) begin
                pc_q  <= entry_pc;
                npc_q <= entry_pc + STEP;
                pal_q <= 1'b1;
            end else if (ret_ok) begin
                pc_q  <= restart_q;
                npc_q <= restart_q + STEP;
                pal_q <= restart_q[0];
            end
        end
    end

    // R5
    intr_pal_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_cause == CZ_INTR && cur_pc[0]) |=> $stable(restart_q));
    // R3
    npc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_q |-> (npc_q == pc_q + STEP));
    // R11
    unsup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unsup_q |-> ($stable(pc_q) && !redir_q));
    // R8
    ret_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_ok |=> (pal_q == $past(restart_q[0])));
    // R13
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_valid && !ret_req) |=> (!redir_q && $stable(pc_q) && $stable(pal_q)));
endmodule

// File: tb/priv_mode_ctrl_test.sv
`timescale 1ns/1ps
module priv_mode_ctrl_test;
    localparam int AW = 32;
    localparam int STRIDE = 'h80;
    localparam logic [AW-1:0] BASE = 32'h0001_0001;

    logic clk = 0, rst_n = 0;
    logic evt_valid = 0, ret_req = 0;
    logic [2:0] evt_cause = 0;
    logic [AW-1:0] cur_pc = 0;
    logic [4:0] rf_idx = 0;
    logic [AW-1:0] pc_q, npc_q, restart_q;
    logic pal_q, bank_q, use_shadow, redir_q, swap_err_q, unsup_q;

    int checks = 0, fails = 0;
    bit done = 0;

    // model state
    logic [AW-1:0] m_pc, m_npc, m_rst;
    logic m_pal, m_bank, m_serr, m_uerr, m_redir;

    always #2 clk = ~clk;

    priv_mode_ctrl #(.AW(AW), .STRIDE(STRIDE)) uut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_cause(evt_cause),
        .ret_req(ret_req), .cur_pc(cur_pc), .pal_base(BASE), .rf_idx(rf_idx),
        .pc_q(pc_q), .npc_q(npc_q), .restart_q(restart_q), .pal_q(pal_q),
        .bank_q(bank_q), .use_shadow(use_shadow), .redir_q(redir_q),
        .swap_err_q(swap_err_q), .unsup_q(unsup_q));

    // Behavioural reference, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = BASE; m_npc = BASE + 4; m_rst = 0; m_pal = 1; m_bank = 1;
            m_serr = 0; m_uerr = 0; m_redir = 0;
        end else begin
            m_serr = 0; m_uerr = 0; m_redir = 0;
            if (evt_valid && evt_cause >= 4) begin
                m_uerr = 1;                                  // R11
            end else if (evt_valid || (ret_req && !cur_pc[0])) begin
                int c;                                       // R10, R12
                c = evt_valid ? int'(evt_cause) : 1;
                if (!(c == 2 && cur_pc[0]))
                    m_rst = (c == 3) ? cur_pc + 4 : cur_pc;  // R4, R5
                if (!cur_pc[0]) begin
                    if (m_bank) m_serr = 1; else m_bank = 1; // R6, R7
                end
                m_pc = BASE + AW'((c + 1) * STRIDE);         // R3
                m_npc = m_pc + 4; m_pal = 1; m_redir = 1;
            end else if (ret_req) begin
                m_pc = m_rst; m_npc = m_rst + 4; m_pal = m_rst[0]; m_redir = 1; // R8
                if (!m_rst[0]) begin
                    if (!m_bank) m_serr = 1; else m_bank = 0; // R9
                end
            end
        end
    end

    task automatic chk(input string req, input string nm, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, nm, act, exp);
        end
    endtask

    // Compare every output against the model, away from the edge.
    task automatic compare_all();
        logic sh;
        sh = m_bank && (((rf_idx >= 8) && (rf_idx <= 14)) || rf_idx == 25);
        chk("R3", "pc_q", pc_q, m_pc);
        chk("R3", "npc_q", npc_q, m_npc);
        chk("R4", "restart_q", restart_q, m_rst);
        chk("R8", "pal_q", AW'(pal_q), AW'(m_pal));
        chk("R6", "bank_q", AW'(bank_q), AW'(m_bank));
        chk("R2", "use_shadow", AW'(use_shadow), AW'(sh));
        chk("R13", "redir_q", AW'(redir_q), AW'(m_redir));
        chk("R7", "swap_err_q", AW'(swap_err_q), AW'(m_serr));
        chk("R11", "unsup_q", AW'(unsup_q), AW'(m_uerr));
    endtask

    task automatic step(input logic ev, input logic [2:0] cz, input logic rt,
                        input logic [AW-1:0] pc, input logic [4:0] idx);
        evt_valid = ev; evt_cause = cz; ret_req = rt; cur_pc = pc; rf_idx = idx;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        compare_all();                          // R1 during reset
        chk("R1", "reset pc", pc_q, BASE);
        rst_n = 1;
        step(0, 0, 0, 0, 5'd8);                 // R1, R13 idle after reset
        step(0, 0, 1, BASE, 5'd9);              // R9 return to 0, bank out
        step(0, 0, 0, 0, 5'd25);                // R13 idle
        step(1, 3'd0, 0, 32'h1000, 5'd10);      // R3 R4 R6 mem fault
        step(1, 3'd2, 0, 32'h1_0101, 5'd25);    // R5 interrupt in handler
        step(0, 0, 1, 32'h1_0105, 5'd15);       // R8 R9 return to 0x1000
        step(1, 3'd3, 0, 32'h2000, 5'd14);      // R4 call saves +4
        step(0, 0, 1, 32'h1_0201, 5'd7);        // R8 return
        step(1, 3'd2, 0, 32'h3000, 5'd26);      // R4 interrupt from normal
        step(1, 3'd1, 0, 32'h1_0301, 5'd11);    // R6 fault inside handler
        step(0, 0, 1, 32'h1_0309, 5'd12);       // R9 return, bit0 set keeps bank
        step(0, 0, 1, 32'h4000, 5'd13);         // R10 R7 illegal return, bank already in
        step(1, 3'd4, 0, 32'h5000, 5'd8);       // R11 arithmetic trap
        step(1, 3'd6, 1, 32'h5001, 5'd8);       // R11 R12 code 6 with return
        step(1, 3'd0, 1, 32'h6001, 5'd8);       // R12 event beats return
        step(1, 3'd1, 0, 32'h7000, 5'd8);       // restart even
        step(0, 0, 1, 32'h1_0001, 5'd8);        // R9 return out
        step(0, 0, 1, 32'h1_0001, 5'd8);        // R7 swap out while already out
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] p;
            p = {16'h0, $urandom_range(0, 32'hffff)[15:0]};
            step($urandom_range(0, 2) == 0, 3'($urandom_range(0, 7)),
                 $urandom_range(0, 1) == 1, p, 5'($urandom_range(0, 31)));
        end
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule